// File: doc/BRIEF.md
# Processor Status Register with Protected Flags

This block holds the 8-bit status word of a small processor core. The word has three ALU flags (zero, digit carry, carry), two power status bits (time-out and power-down) and three bank select bits for data memory. The register file writes it like any other location. The ALU can also update any flag directly, one strobe per flag. Three system events move the power bits: a watchdog clear, sleep entry and a watchdog time-out.

Writes are arbitrated bit by bit. A flag that the current instruction updates takes the ALU value, and the written data for that bit is dropped. The power bits never take written data. They are driven by a small state machine with four named states:

| State | Time-out | Power-down |
|---|---|---|
| `ST_RUN_OK` | 1 | 1 |
| `ST_SLEPT` | 1 | 0 |
| `ST_WDT_RUN` | 0 | 1 |
| `ST_WDT_SLEPT` | 0 | 0 |

The state machine makes these transitions:
- Reset goes to `ST_RUN_OK`.
- A watchdog clear goes to `ST_RUN_OK`.
- Sleep goes to `ST_SLEPT`.
- A time-out goes from `ST_RUN_OK` or `ST_WDT_RUN` to `ST_WDT_RUN`.
- A time-out goes from `ST_SLEPT` or `ST_WDT_SLEPT` to `ST_WDT_SLEPT`.

With no event, the state is held. The bank bits also form the upper bits of the 9-bit data memory addresses:
- A direct access uses the two direct bank bits above a 7-bit offset.
- An indirect access uses the indirect bank bit above an 8-bit pointer.

Top module: `cpu_status_reg`

## Requirements
- R1: The layout is fixed, from bit 7 down to bit 0: indirect bank, direct bank high, direct bank low, time-out, power-down, zero, digit carry, carry. After reset (`rst_n` low, the power-on event), the status reads 8'h18: bank bits 0, time-out 1, power-down 1, and the flags are 0.
- R2: A write with no flag strobe loads bits 7:5 and 2:0 from `wr_data` on the next rising edge.
- R3: When a flag's update strobe is high, that flag takes the ALU value and ignores `wr_data`. Flags without a strobe still take `wr_data` if a write is present.
- R4: A flag update strobe without a write changes only that flag.
- R5: Register writes never change time-out (bit 4) or power-down (bit 3). For example, writing 8'h00 from 8'h18 while the zero strobe sets zero gives 8'h1C.
- R6: A watchdog clear sets time-out to 1 and power-down to 1.
- R7: Sleep entry sets time-out to 1 and clears power-down to 0.
- R8: A watchdog time-out clears time-out and leaves power-down unchanged. When events coincide, time-out has the highest priority, then sleep, then clear.
- R9: When an event and a write occur in the same cycle, the event decides bits 4:3 and the write decides the other bits.
- R10: `dir_addr` equals {bit 6, bit 5, `dir_ofs`}, combinationally.
- R11: `ind_addr` equals {bit 7, `ind_ptr`}, combinationally.
- R12: With no write, no strobe and no event, the status holds its value. Reading it has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Register-file write to the status word |
| wr_data | input | 8 | Data written |
| upd_z | input | 1 | ALU updates zero |
| z_new | input | 1 | New zero value |
| upd_dc | input | 1 | ALU updates digit carry |
| dc_new | input | 1 | New digit carry value |
| upd_c | input | 1 | ALU updates carry |
| c_new | input | 1 | New carry value |
| ev_wdt_clr | input | 1 | Watchdog clear command |
| ev_sleep | input | 1 | Sleep entry |
| ev_wdt_to | input | 1 | Watchdog time-out |
| dir_ofs | input | 7 | Direct-access offset |
| ind_ptr | input | 8 | Indirect-access pointer |
| status | output | 8 | Current status word |
| dir_addr | output | 9 | Direct data memory address |
| ind_addr | output | 9 | Indirect data memory address |

## Verification
Directed sequences come first, and each one separates a single rule:
- A write of all zeros with the zero strobe set shows that the power bits are protected while the flag arbitration still applies.
- A write of all ones with each strobe in turn, carrying the opposite value, shows that arbitration is per bit and not per word.
- Each event alone and in pairs, from each power state, separates the priority order and the power-down retention on time-out.

A long random phase then mixes writes, strobes and events in every combination against a reference model. That phase exposes any cross-coupling between the bit groups and any wrong address concatenation.

// File: rtl/status_pkg.sv
package status_pkg;

    typedef struct packed {
        logic       bnk_ind;
        logic [1:0] bnk_dir;
        logic       to;
        logic       pd;
        logic       z;
        logic       dc;
        logic       c;
    } status_t;

    typedef enum logic [1:0] {
        ST_RUN_OK    = 2'd0,
        ST_SLEPT     = 2'd1,
        ST_WDT_RUN   = 2'd2,
        ST_WDT_SLEPT = 2'd3
    } pwr_state_e;

    localparam logic [2:0] FLAG_RESET = 3'b000;

endpackage

// File: rtl/pwr_status_fsm.sv
module pwr_status_fsm
    import status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_wdt_clr,
    input  logic ev_sleep,
    input  logic ev_wdt_to,
    output logic to_o,
    output logic pd_o
);

    pwr_state_e state_q;
    pwr_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (ev_wdt_to) begin
            unique case (state_q)
                ST_RUN_OK, ST_WDT_RUN:  state_d = ST_WDT_RUN;
                ST_SLEPT, ST_WDT_SLEPT: state_d = ST_WDT_SLEPT;
                default:                state_d = ST_RUN_OK;
            endcase
        end else if (ev_sleep) begin
            state_d = ST_SLEPT;
        end else if (ev_wdt_clr) begin
            state_d = ST_RUN_OK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN_OK;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_RUN_OK:    begin to_o = 1'b1; pd_o = 1'b1; end
            ST_SLEPT:     begin to_o = 1'b1; pd_o = 1'b0; end
            ST_WDT_RUN:   begin to_o = 1'b0; pd_o = 1'b1; end
            ST_WDT_SLEPT: begin to_o = 1'b0; pd_o = 1'b0; end
            default:      begin to_o = 1'b1; pd_o = 1'b1; end
        endcase
    end

endmodule

// File: rtl/flag_arbiter.sv
module flag_arbiter
    import status_pkg::*;
#(
    parameter int NFLAG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [NFLAG-1:0] wr_bits,
    input  logic [NFLAG-1:0] upd,
    input  logic [NFLAG-1:0] val,
    output logic [NFLAG-1:0] flags_q
);

    localparam logic [NFLAG-1:0] RST_VAL = NFLAG'(FLAG_RESET);

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        logic nxt;
        always_comb begin
            if (upd[i])     nxt = val[i];
            else if (wr_en) nxt = wr_bits[i];
            else            nxt = flags_q[i];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags_q[i] <= RST_VAL[i];
            else        flags_q[i] <= nxt;
        end
    end

endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen #(
    parameter int DIR_OFS_W = 7,
    parameter int IND_PTR_W = 8,
    localparam int DIR_AW   = DIR_OFS_W + 2,
    localparam int IND_AW   = IND_PTR_W + 1
) (
    input  logic                 bnk_ind,
    input  logic [1:0]           bnk_dir,
    input  logic [DIR_OFS_W-1:0] dir_ofs,
    input  logic [IND_PTR_W-1:0] ind_ptr,
    output logic [DIR_AW-1:0]    dir_addr,
    output logic [IND_AW-1:0]    ind_addr
);

    always_comb begin
        dir_addr = {bnk_dir, dir_ofs};
        ind_addr = {bnk_ind, ind_ptr};
    end

endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
    import status_pkg::*;
#(
    parameter int DIR_OFS_W = 7,
    parameter int IND_PTR_W = 8,
    localparam int DIR_AW   = DIR_OFS_W + 2,
    localparam int IND_AW   = IND_PTR_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [7:0]           wr_data,
    input  logic                 upd_z,
    input  logic                 z_new,
    input  logic                 upd_dc,
    input  logic                 dc_new,
    input  logic                 upd_c,
    input  logic                 c_new,
    input  logic                 ev_wdt_clr,
    input  logic                 ev_sleep,
    input  logic                 ev_wdt_to,
    input  logic [DIR_OFS_W-1:0] dir_ofs,
    input  logic [IND_PTR_W-1:0] ind_ptr,
    output logic [7:0]           status,
    output logic [DIR_AW-1:0]    dir_addr,
    output logic [IND_AW-1:0]    ind_addr
);

    status_t    wr_view;
    status_t    cur;
    logic [2:0] bank_q;
    logic [2:0] flags_q;
    logic       to_s;
    logic       pd_s;
    logic       unused_pwr_wr;

    assign wr_view       = status_t'(wr_data);
    assign unused_pwr_wr = wr_view.to ^ wr_view.pd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bank_q <= 3'b000;
        else if (wr_en) bank_q <= {wr_view.bnk_ind, wr_view.bnk_dir};
    end

    flag_arbiter #(.NFLAG(3)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bits ({wr_view.z, wr_view.dc, wr_view.c}),
        .upd     ({upd_z, upd_dc, upd_c}),
        .val     ({z_new, dc_new, c_new}),
        .flags_q (flags_q)
    );

    pwr_status_fsm u_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_wdt_clr (ev_wdt_clr),
        .ev_sleep   (ev_sleep),
        .ev_wdt_to  (ev_wdt_to),
        .to_o       (to_s),
        .pd_o       (pd_s)
    );

    always_comb begin
        cur.bnk_ind = bank_q[2];
        cur.bnk_dir = bank_q[1:0];
        cur.to      = to_s;
        cur.pd      = pd_s;
        cur.z       = flags_q[2];
        cur.dc      = flags_q[1];
        cur.c       = flags_q[0];
    end

    assign status = cur;

    bank_addr_gen #(.DIR_OFS_W(DIR_OFS_W), .IND_PTR_W(IND_PTR_W)) u_addr (
        .bnk_ind  (cur.bnk_ind),
        .bnk_dir  (cur.bnk_dir),
        .dir_ofs  (dir_ofs),
        .ind_ptr  (ind_ptr),
        .dir_addr (dir_addr),
        .ind_addr (ind_addr)
    );

endmodule

// File: rtl/status_reg_checker.sv
module status_reg_checker #(
    parameter int DIR_OFS_W = 7,
    parameter int IND_PTR_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [7:0]           wr_data,
    input logic                 upd_z,
    input logic                 z_new,
    input logic                 upd_c,
    input logic                 ev_wdt_clr,
    input logic                 ev_sleep,
    input logic                 ev_wdt_to,
    input logic [DIR_OFS_W-1:0] dir_ofs,
    input logic [IND_PTR_W-1:0] ind_ptr,
    input logic [7:0]           status,
    input logic [DIR_OFS_W+1:0] dir_addr,
    input logic [IND_PTR_W:0]   ind_addr
);

    logic any_ev;
    assign any_ev = ev_wdt_clr | ev_sleep | ev_wdt_to;

    AST_WR_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> status[7:5] == $past(wr_data[7:5])); // R2

    AST_Z_STROBE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        upd_z |=> status[2] == $past(z_new)); // R3

    AST_C_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !upd_c) |=> status[0] == $past(wr_data[0])); // R2

    AST_PWR_WRITE_PROOF: assert property (@(posedge clk) disable iff (!rst_n)
        !any_ev |=> $stable(status[4:3])); // R5

    AST_CLR_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wdt_clr && !ev_sleep && !ev_wdt_to) |=> status[4:3] == 2'b11); // R6

    AST_SLEEP_PD: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sleep && !ev_wdt_to) |=> status[4:3] == 2'b10); // R7

    AST_TIMEOUT_TO: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wdt_to |=> (!status[4] && status[3] == $past(status[3]))); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !upd_z && !upd_c && !any_ev) |=> $stable(status[7:2]) && $stable(status[0])); // R12

    always_comb begin
        if (rst_n) begin
            AST_DIR_ADDR: assert (dir_addr[DIR_OFS_W+1 -: 2] == status[6:5] && dir_addr[DIR_OFS_W-1:0] == dir_ofs); // R10
            AST_IND_ADDR: assert (ind_addr[IND_PTR_W] == status[7] && ind_addr[IND_PTR_W-1:0] == ind_ptr); // R11
        end
    end

endmodule

bind cpu_status_reg status_reg_checker #(.DIR_OFS_W(DIR_OFS_W), .IND_PTR_W(IND_PTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .upd_z      (upd_z),
    .z_new      (z_new),
    .upd_c      (upd_c),
    .ev_wdt_clr (ev_wdt_clr),
    .ev_sleep   (ev_sleep),
    .ev_wdt_to  (ev_wdt_to),
    .dir_ofs    (dir_ofs),
    .ind_ptr    (ind_ptr),
    .status     (status),
    .dir_addr   (dir_addr),
    .ind_addr   (ind_addr)
);

// File: tb/cpu_status_reg_bench.sv
`timescale 1ns/1ps
module cpu_status_reg_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 0, upd_z = 0, z_new = 0, upd_dc = 0, dc_new = 0, upd_c = 0, c_new = 0;
    logic       ev_wdt_clr = 0, ev_sleep = 0, ev_wdt_to = 0;
    logic [7:0] wr_data = 0;
    logic [6:0] dir_ofs = 0;
    logic [7:0] ind_ptr = 0;
    logic [7:0] status;
    logic [8:0] dir_addr;
    logic [8:0] ind_addr;

    int vectors = 0;
    int fails   = 0;
    int m_st    = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    cpu_status_reg u_cpu_status_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .upd_z(upd_z), .z_new(z_new), .upd_dc(upd_dc), .dc_new(dc_new),
        .upd_c(upd_c), .c_new(c_new), .ev_wdt_clr(ev_wdt_clr),
        .ev_sleep(ev_sleep), .ev_wdt_to(ev_wdt_to), .dir_ofs(dir_ofs),
        .ind_ptr(ind_ptr), .status(status), .dir_addr(dir_addr), .ind_addr(ind_addr)
    );

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int model_next(int s);
        int n = s;
        int to = (s >> 4) & 1;
        int pd = (s >> 3) & 1;
        if (wr_en) n = (n & 8'h18) | (int'(wr_data) & 8'hE7);
        if (upd_z)  n = (n & ~4) | (z_new  << 2);
        if (upd_dc) n = (n & ~2) | (dc_new << 1);
        if (upd_c)  n = (n & ~1) | c_new;
        if (ev_wdt_to)       to = 0;
        else if (ev_sleep)   begin to = 1; pd = 0; end
        else if (ev_wdt_clr) begin to = 1; pd = 1; end
        return (n & 8'hE7) | (to << 4) | (pd << 3);
    endfunction

    task automatic step(string req);
        @(posedge clk);
        m_st = model_next(m_st);
        @(negedge clk);
        check(req, status, m_st);
        check("R10", dir_addr, ((m_st >> 5) & 3) * 128 + dir_ofs);
        check("R11", ind_addr, ((m_st >> 7) & 1) * 256 + ind_ptr);
        {wr_en, upd_z, upd_dc, upd_c, ev_wdt_clr, ev_sleep, ev_wdt_to} = '0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", status, 8'h18);
        rst_n = 1'b1;
        m_st = 8'h18;
        // R5: write zeros while zero strobe sets zero -> 8'h1C
        wr_en = 1; wr_data = 8'h00; upd_z = 1; z_new = 1; step("R5");
        check("R5", status, 8'h1C);
        // R2: plain write of all ones, power bits untouched
        wr_en = 1; wr_data = 8'hFF; step("R2");
        check("R2", status, 8'hFF);
        // R3: per-bit arbitration
        wr_en = 1; wr_data = 8'hFF; upd_dc = 1; dc_new = 0; step("R3");
        check("R3", status, 8'hFD);
        wr_en = 1; wr_data = 8'h00; upd_c = 1; c_new = 1; step("R3");
        check("R3", status, 8'h19);
        // R4: strobe only
        upd_z = 1; z_new = 1; step("R4");
        check("R4", status, 8'h1D);
        // R12 idle hold
        dir_ofs = 7'h55; ind_ptr = 8'hA3; step("R12"); step("R12");
        // R7 sleep, R8 timeout keeps pd, R6 clear
        ev_sleep = 1; step("R7");
        check("R7", status[4:3], 2'b10);
        ev_wdt_to = 1; step("R8");
        check("R8", status[4:3], 2'b00);
        ev_wdt_clr = 1; step("R6");
        check("R6", status[4:3], 2'b11);
        ev_wdt_to = 1; ev_sleep = 1; ev_wdt_clr = 1; step("R8");
        check("R8", status[4:3], 2'b01);
        ev_sleep = 1; ev_wdt_clr = 1; step("R8");
        check("R8", status[4:3], 2'b10);
        // R9 event with write
        wr_en = 1; wr_data = 8'hE7; ev_wdt_to = 1; step("R9");
        check("R9", status, 8'hE0 | 8'h07);
        wr_en = 1; wr_data = 8'h18; ev_wdt_clr = 1; step("R9");
        check("R9", status, 8'h18);
        for (int i = 0; i < 3000; i++) begin
            wr_en = $urandom_range(0, 1) == 1;
            wr_data = 8'($urandom);
            {upd_z, z_new, upd_dc, dc_new, upd_c, c_new} = 6'($urandom);
            ev_wdt_clr = $urandom_range(0, 5) == 0;
            ev_sleep   = $urandom_range(0, 5) == 0;
            ev_wdt_to  = $urandom_range(0, 5) == 0;
            dir_ofs = 7'($urandom);
            ind_ptr = 8'($urandom);
            step("R9");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule